// File: doc/BRIEF.md
# Multi-bank GPIO register controller

This block is a memory-mapped general-purpose I/O peripheral serving sixteen pins. The pins are split into four banks of 2, 4, 4 and 6 pins. Each bank has one data register and one configuration register. A single drive-select register covers all sixteen pins and chooses push-pull or open-drain output for each one. Software reaches the registers over a simple bus with valid, write, address and data signals. A write takes effect at the clock edge on which it is presented. A read returns data combinationally in the same cycle.

Each pin has a 4-bit mode field. Only the output mode code turns the pin's driver on. Pins in any other mode are treated as inputs. Their level passes through a two-stage synchronizer and can then be read from the bank's data register. A pin in output mode instead reads back the level that software last wrote to it.

Top module: `gpio_multibank`

## Requirements
- R1: After reset, every mapped register reads 0, `pinOe` is all 0, and every pin is push-pull.
- R2: Only these word addresses are mapped: bank data at 0x170, 0x174, 0x178 and 0x17C; bank configuration at 0x180, 0x184, 0x188 and 0x18C; drive select at 0x190. Any other address reads 0, and a write to it changes no register.
- R3: Banks 0 to 3 hold pins 0-1, 2-5, 6-9 and 10-15. Bit n of a bank's data register belongs to pin (bank base + n), and writing it sets the level driven on that pin.
- R4: In a configuration register, the mode field of local pin n is bits [4n+3:4n], and it reads back as written.
- R5: A pin's driver is enabled only when its mode field equals 0x8. Mode 0x1 and every other value leave `pinOe` low.
- R6: Bit p of the drive-select register set to 1 makes pin p open-drain. An enabled open-drain pin with data 0 drives low, and one with data 1 is released (`pinOe` = 0). A push-pull pin drives its data bit on `pinOut`.
- R7: A pin that is not in output mode reads back its synchronized input. A level applied before clock edge k appears in the data register read after edge k+1.
- R8: A pin in output mode reads back its latched data bit, whatever level is on `pinIn`.
- R9: Data bits at or above a bank's pin count, configuration bits at or above 4 times that count, and drive-select bits 31:16 all read 0 and ignore writes.
- R10: `busRdata` carries the addressed register while `busValid` is high and `busWrite` is low, and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | A bus access is present this cycle |
| busWrite | input | 1 | 1 for a write access, 0 for a read |
| busAddr | input | 12 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| pinIn | input | 16 | Sampled pin levels |
| pinOut | output | 16 | Level driven on each pin |
| pinOe | output | 16 | Driver enable for each pin |

## Verification
Some rules are checked by assertions on every cycle:
- at most one register is written per access;
- no write strobe appears without a bus write;
- a pin's driver is never enabled outside mode 0x8;
- an open-drain pin never drives high;
- each data and mode write lands on the correct pin in the next cycle.

Other behaviours can only be shown by the bench's scenarios:
- the exact address map, including the unmapped holes;
- masking of the unused bits above each bank's pin count;
- read-back of output pins versus synchronized input pins;
- the two-edge synchronizer delay;
- the combinational read timing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS  = 16;
  localparam int NUM_BANKS = 4;
  localparam int MODE_W    = 4;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  localparam int BANK_BASE  [NUM_BANKS] = '{0, 2, 6, 10};
  localparam int BANK_WIDTH [NUM_BANKS] = '{2, 4, 4, 6};

  localparam logic [MODE_W-1:0] MODE_IN  = 4'h1;
  localparam logic [MODE_W-1:0] MODE_OUT = 4'h8;

  localparam logic [ADDR_W-1:0] DATA_ADDR0  = 12'h170;
  localparam logic [ADDR_W-1:0] CFG_ADDR0   = 12'h180;
  localparam logic [ADDR_W-1:0] DRIVE_ADDR  = 12'h190;

  typedef enum logic [1:0] {RD_NONE, RD_DATA, RD_CFG, RD_DRIVE} rdSel_e;

  typedef struct packed {
    logic [NUM_BANKS-1:0]  dataWe;
    logic [NUM_BANKS-1:0]  cfgWe;
    logic                  driveWe;
    rdSel_e                rdSel;
    logic [BANK_IDX_W-1:0] rdBank;
  } gpioStrobe_t;

  function automatic int pinBank(int p);
    int bk = 0;
    for (int b = 0; b < NUM_BANKS; b++) if (p >= BANK_BASE[b]) bk = b;
    return bk;
  endfunction

  function automatic int pinLocal(int p);
    return p - BANK_BASE[pinBank(p)];
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrobe_t       ctl
);
  logic [NUM_BANKS-1:0] dataHit, cfgHit;
  logic driveHit, wrReq, rdReq;

  assign wrReq = busValid & busWrite;
  assign rdReq = busValid & ~busWrite;

  always_comb begin
    dataHit = '0;
    cfgHit  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      dataHit[b] = (busAddr == DATA_ADDR0 + ADDR_W'(4 * b));
      cfgHit[b]  = (busAddr == CFG_ADDR0 + ADDR_W'(4 * b));
    end
    driveHit = (busAddr == DRIVE_ADDR);
  end

  always_comb begin
    ctl = '0;
    ctl.dataWe  = dataHit & {NUM_BANKS{wrReq}};
    ctl.cfgWe   = cfgHit & {NUM_BANKS{wrReq}};
    ctl.driveWe = driveHit & wrReq;
    ctl.rdSel   = RD_NONE;
    if (rdReq) begin
      if (|dataHit)     ctl.rdSel = RD_DATA;
      else if (|cfgHit) ctl.rdSel = RD_CFG;
      else if (driveHit) ctl.rdSel = RD_DRIVE;
    end
    for (int b = 0; b < NUM_BANKS; b++)
      if (dataHit[b] | cfgHit[b]) ctl.rdBank = BANK_IDX_W'(b);
  end

  // R2: one register per access at most
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.dataWe, ctl.cfgWe, ctl.driveWe}));
  // R2: nothing written without a bus write
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && busWrite) |-> ({ctl.dataWe, ctl.cfgWe, ctl.driveWe} == '0));
  // R10: read select only during a read
  assert_read_only_on_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdSel != RD_NONE) |-> (busValid && !busWrite));
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  gpioStrobe_t         ctl,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  logic [NUM_PINS-1:0] dataQ, odQ, syncA, syncB;
  logic [MODE_W-1:0]   modeQ [NUM_PINS];
  logic [DATA_W-1:0]   bankDataRd [NUM_BANKS];
  logic [DATA_W-1:0]   bankCfgRd  [NUM_BANKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      odQ   <= '0;
      syncA <= '0;
      syncB <= '0;
      for (int p = 0; p < NUM_PINS; p++) modeQ[p] <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (ctl.driveWe) odQ <= busWdata[NUM_PINS-1:0];
      for (int p = 0; p < NUM_PINS; p++) begin
        if (ctl.dataWe[pinBank(p)]) dataQ[p] <= busWdata[pinLocal(p)];
        if (ctl.cfgWe[pinBank(p)])  modeQ[p] <= busWdata[MODE_W*pinLocal(p) +: MODE_W];
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] dRd, cRd;
    always_comb begin
      dRd = '0;
      cRd = '0;
      for (int n = 0; n < BANK_WIDTH[b]; n++) begin
        dRd[n] = (modeQ[BANK_BASE[b]+n] == MODE_OUT) ? dataQ[BANK_BASE[b]+n]
                                                     : syncB[BANK_BASE[b]+n];
        cRd[MODE_W*n +: MODE_W] = modeQ[BANK_BASE[b]+n];
      end
    end
    assign bankDataRd[b] = dRd;
    assign bankCfgRd[b]  = cRd;
  end

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (odQ[p]) begin
        pinOe[p]  = (modeQ[p] == MODE_OUT) & ~dataQ[p];
        pinOut[p] = 1'b0;
      end else begin
        pinOe[p]  = (modeQ[p] == MODE_OUT);
        pinOut[p] = dataQ[p];
      end
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_DATA:  busRdata = bankDataRd[ctl.rdBank];
      RD_CFG:   busRdata = bankCfgRd[ctl.rdBank];
      RD_DRIVE: busRdata = DATA_W'(odQ);
      default:  busRdata = '0;
    endcase
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    localparam int B = pinBank(p);
    localparam int L = pinLocal(p);
    // R5: driver on only in output mode
    assert_oe_needs_out_R5: assert property (@(posedge clk) disable iff (!rstN)
      pinOe[p] |-> (modeQ[p] == MODE_OUT));
    // R6: open-drain pin never drives high
    assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rstN)
      (odQ[p] && pinOe[p]) |-> !pinOut[p]);
    // R3: bank data bit lands on its pin
    assert_data_lands_R3: assert property (@(posedge clk) disable iff (!rstN)
      ctl.dataWe[B] |=> (dataQ[p] == $past(busWdata[L])));
    // R4: mode field lands on its pin
    assert_mode_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctl.cfgWe[B] |=> (modeQ[p] == $past(busWdata[MODE_W*L +: MODE_W])));
  end
endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
  import gpio_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);
  gpioStrobe_t ctl;

  gpio_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .ctl(ctl)
  );

  gpio_datapath dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata), .pinIn(pinIn),
    .busRdata(busRdata), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: tb/gpio_multibank_tb.sv
module gpio_multibank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOut, pinOe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_multibank dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write at a negedge, takes effect at the next posedge; returns 1 unit after it
  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
  endtask

  // combinational read, no clock edge consumed
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busValid = 0;
  endtask

  task automatic rdChk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic testReset();
    for (int b = 0; b < 4; b++) begin
      rdChk("R1 data", 12'h170 + 12'(4*b), 0);
      rdChk("R1 cfg", 12'h180 + 12'(4*b), 0);
    end
    rdChk("R1 drive", 12'h190, 0);
    chk("R1 oe", 32'(pinOe), 0);
  endtask

  task automatic testConfig();
    wr(12'h184, 32'h8181);
    rdChk("R4 cfg bank1", 12'h184, 32'h8181);
    wr(12'h184, 32'h0);
    wr(12'h180, 32'hFFFF_FFFF);
    rdChk("R9 cfg bank0 mask", 12'h180, 32'h0000_00FF);
    wr(12'h180, 32'h0);
  endtask

  task automatic testBankMap();
    wr(12'h180, 32'h88);
    wr(12'h170, 32'h3);
    chk("R3 bank0 pins out", 32'(pinOut & 16'h003F), 32'h3);
    chk("R3 bank0 pins oe", 32'(pinOe), 32'h3);
    wr(12'h170, 32'h0);
    wr(12'h180, 32'h0);
  endtask

  task automatic testOutput();
    wr(12'h18C, 32'h888888);
    wr(12'h17C, 32'h2A);
    chk("R6 push-pull out", 32'(pinOut[15:10]), 32'h2A);
    chk("R3 bank3 oe", 32'(pinOe), 32'hFC00);
    rdChk("R8 output readback", 12'h17C, 32'h2A);
    wr(12'h17C, 32'hFFFF);
    rdChk("R9 data mask", 12'h17C, 32'h3F);
    wr(12'h17C, 32'h2A);
  endtask

  task automatic testOpenDrain();
    wr(12'h190, 32'hFC00);
    rdChk("R6 drive readback", 12'h190, 32'hFC00);
    chk("R6 od oe", 32'(pinOe), 32'h5400);
    chk("R6 od out low", 32'(pinOut[15:10]), 0);
    wr(12'h190, 32'hFFFF_FFFF);
    rdChk("R9 drive mask", 12'h190, 32'hFFFF);
    wr(12'h190, 32'h0);
  endtask

  task automatic testModes();
    wr(12'h18C, 32'h111111);
    chk("R5 input mode oe", 32'(pinOe), 0);
    wr(12'h18C, 32'h444444);
    chk("R5 other mode oe", 32'(pinOe), 0);
    wr(12'h18C, 32'h0);
  endtask

  task automatic testSync();
    wr(12'h188, 32'h1111);
    @(negedge clk);
    pinIn = 16'h0140;
    rdChk("R7 before edge", 12'h178, 0);
    @(posedge clk); #1;
    rdChk("R7 one edge", 12'h178, 0);
    @(posedge clk); #1;
    rdChk("R7 two edges", 12'h178, 32'h5);
    wr(12'h18C, 32'h888888);
    pinIn = 16'hFC00;
    repeat (3) @(posedge clk);
    #1 rdChk("R8 ignores pinIn", 12'h17C, 32'h2A);
  endtask

  task automatic testUnmapped();
    logic [15:0] oeBefore;
    oeBefore = pinOe;
    wr(12'h194, 32'hFFFF_FFFF);
    wr(12'h17D, 32'hFFFF_FFFF);
    chk("R2 unmapped write", 32'(pinOe), 32'(oeBefore));
    rdChk("R2 unmapped read", 12'h194, 0);
    rdChk("R2 drive untouched", 12'h190, 0);
    @(negedge clk);
    busAddr = 12'h18C; busValid = 0;
    #1 chk("R10 idle rdata", busRdata, 0);
    busValid = 1; busWrite = 1;
    #1 chk("R10 write rdata", busRdata, 0);
    busValid = 0; busWrite = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    testReset();
    testConfig();
    testBankMap();
    testOutput();
    testOpenDrain();
    testModes();
    testSync();
    testUnmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule